// File: doc/BRIEF.md
# Linked-Descriptor Display Fetch Engine

This block keeps a display pipeline supplied with words from memory. It does not take a fixed frame address. It walks a chain of four-word descriptors. Each descriptor holds a link to the following descriptor, the source address of a run of data, a frame tag, and a command word. The command word carries the run length in 32-bit words and a flag that marks the run as colour-table (palette) data instead of frame data. A chain whose single descriptor links to itself refetches the same frame without end. Two descriptors that link to each other alternate a palette load with a frame load.

The engine is started once with a pulse and the address of the first descriptor. From then on it follows the chain and does not stop. It reads memory in bursts over a plain request/grant interface, and read data returns in order with a per-word valid. The burst size is picked from three sizes. The engine only asks for a burst when its output FIFO has room for the whole burst. The display side pops words from the FIFO. A pop that finds the FIFO empty raises a sticky underrun flag. If repeat-on-empty was enabled at start, the output shows the last word that was delivered; otherwise it shows zero.

Top module: `fb_desc_fetch`

## Requirements
- R1: While rst_ni is low and after its release, mem_req_o, pix_valid_o, underrun_o and frame_id_o are all 0 until a start is given.
- R2: On start_i while idle, the engine requests 4 words at desc_addr_i. The words are taken in this order: link to the next descriptor, source address, frame tag, command. frame_id_o shows the frame tag once the descriptor has been read.
- R3: Data words are read from consecutive addresses, starting at the source address and stepping by 4 bytes. They appear at pix_data_o in memory order, and their count equals command bits [LEN_W-1:0].
- R4: burst_sel_i, latched at start, sets the burst size: 0 gives 4 words, 1 gives 8, 2 gives 16, and 3 gives 4. Every data request has mem_len_o equal to the smaller of the burst size and the words still left in the run. Descriptor requests use length 4.
- R5: A data request is raised only when the FIFO has free space for the whole request, so the FIFO never overflows.
- R6: The next descriptor, at the link address, is requested only after the word count of the current run has reached zero. A run of length 0 goes straight to its linked descriptor. A descriptor that links to itself is fetched again after each run.
- R7: When command bit 28 is set, every word of that run is shown with pix_pal_o = 1. When it is clear, pix_pal_o = 0.
- R8: A pix_rd_i while pix_valid_o is 0 sets underrun_o. underrun_o then stays set until reset, and the FIFO contents are not disturbed.
- R9: While pix_valid_o is 0, pix_data_o shows the last popped word if hold_en_i was 1 at start (0 if none has been popped yet). If hold_en_i was 0 at start, pix_data_o shows 0.
- R10: A raised mem_req_o stays raised, with mem_addr_o and mem_len_o unchanged, until the cycle in which mem_gnt_i is 1.
- R11: A word pushed from memory and a word popped by the display in the same cycle both take effect, and neither is lost.
- R12: start_i, desc_addr_i, burst_sel_i and hold_en_i have no effect once the engine has left idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, honoured only while idle |
| desc_addr_i | input | 32 | Byte address of the first descriptor |
| burst_sel_i | input | 2 | Burst size select |
| hold_en_i | input | 1 | Repeat last word when the FIFO is empty |
| mem_req_o | output | 1 | Read burst request |
| mem_addr_o | output | 32 | Byte address of the burst |
| mem_len_o | output | 5 | Burst length in words |
| mem_gnt_i | input | 1 | Request accepted |
| mem_rvalid_i | input | 1 | Read data word valid |
| mem_rdata_i | input | 32 | Read data word |
| pix_rd_i | input | 1 | Display pops one word |
| pix_valid_o | output | 1 | FIFO holds at least one word |
| pix_data_o | output | 32 | Head word, or the empty-FIFO value |
| pix_pal_o | output | 1 | Head word belongs to a palette run |
| frame_id_o | output | 32 | Frame tag of the latest descriptor |
| underrun_o | output | 1 | Sticky empty-pop flag |

## Verification
Two events can land on the FIFO in the same cycle. A memory word can be pushed while the display pops, and that pop can fall on a FIFO that is empty in the same cycle the first word of a burst arrives. Both cases are provoked in phases where the display pops on nearly every cycle and memory answers quickly. The bench checks that such a pop counts as an underrun and does not consume the arriving word. That word must then appear on the next pop, in chain order. Same-cycle push and pop on a non-empty FIFO are judged by the word stream staying complete and by the bench's own occupancy count agreeing with the free-space check at each grant.

// File: rtl/fbf_pkg.sv
package fbf_pkg;
  localparam int MAX_BURST  = 16;
  localparam int BLEN_W     = $clog2(MAX_BURST) + 1;
  localparam int DESC_WORDS = 4;
  localparam int PAL_BIT    = 28;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DREQ, ST_DRCV, ST_BREQ, ST_BRCV
  } fetch_st_e;

  function automatic logic [BLEN_W-1:0] burst_words(input logic [1:0] sel);
    case (sel)
      2'd1:    burst_words = BLEN_W'(8);
      2'd2:    burst_words = BLEN_W'(16);
      default: burst_words = BLEN_W'(4);
    endcase
  endfunction
endpackage

// File: rtl/fbf_fifo.sv
module fbf_fifo #(
  parameter  int WIDTH = 33,
  parameter  int DEPTH = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             valid_o,
  output logic [CNT_W-1:0] free_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_pop;

  assign valid_o = (cnt_q != '0);
  assign do_pop  = pop_i && valid_o;
  assign rdata_o = mem_q[rd_q];
  assign free_o  = CNT_W'(DEPTH) - cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= wr_q + 1'b1;
      if (do_pop) rd_q <= rd_q + 1'b1;
      case ({push_i, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !do_pop |-> cnt_q != CNT_W'(DEPTH)); // R5
endmodule

// File: rtl/fbf_fetch_ctl.sv
module fbf_fetch_ctl
  import fbf_pkg::*;
#(
  parameter int LEN_W = 24,
  parameter int CNT_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [31:0]       desc_addr_i,
  input  logic [1:0]        burst_sel_i,
  input  logic [CNT_W-1:0]  free_i,
  output logic              idle_o,
  output logic              mem_req_o,
  output logic [31:0]       mem_addr_o,
  output logic [BLEN_W-1:0] mem_len_o,
  input  logic              mem_gnt_i,
  input  logic              mem_rvalid_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              push_o,
  output logic              push_pal_o,
  output logic [31:0]       frame_id_o
);
  fetch_st_e         st_q;
  logic [31:0]       desc_q, next_q, src_q, fid_q;
  logic [LEN_W-1:0]  rem_q;
  logic              pal_q;
  logic [1:0]        widx_q;
  logic [BLEN_W-1:0] blen_q, beats_q, cur_len;

  // words for the next burst: full burst or the tail of the run
  assign cur_len = (rem_q < LEN_W'(blen_q)) ? BLEN_W'(rem_q) : blen_q;

  assign idle_o     = (st_q == ST_IDLE);
  assign mem_req_o  = (st_q == ST_DREQ) ||
                      (st_q == ST_BREQ && rem_q != '0 && free_i >= CNT_W'(cur_len));
  assign mem_addr_o = (st_q == ST_DREQ) ? desc_q : src_q;
  assign mem_len_o  = (st_q == ST_DREQ) ? BLEN_W'(DESC_WORDS) : cur_len;
  assign push_o     = (st_q == ST_BRCV) && mem_rvalid_i;
  assign push_pal_o = pal_q;
  assign frame_id_o = fid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      desc_q  <= '0;
      next_q  <= '0;
      src_q   <= '0;
      fid_q   <= '0;
      rem_q   <= '0;
      pal_q   <= 1'b0;
      widx_q  <= '0;
      blen_q  <= BLEN_W'(4);
      beats_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin
          desc_q <= desc_addr_i;
          blen_q <= burst_words(burst_sel_i);
          st_q   <= ST_DREQ;
        end
        ST_DREQ: if (mem_gnt_i) begin
          widx_q <= '0;
          st_q   <= ST_DRCV;
        end
        ST_DRCV: if (mem_rvalid_i) begin
          widx_q <= widx_q + 1'b1;
          case (widx_q)
            2'd0: next_q <= mem_rdata_i;
            2'd1: src_q  <= mem_rdata_i;
            2'd2: fid_q  <= mem_rdata_i;
            default: begin
              rem_q <= mem_rdata_i[LEN_W-1:0];
              pal_q <= mem_rdata_i[PAL_BIT];
              st_q  <= ST_BREQ;
            end
          endcase
        end
        ST_BREQ: begin
          if (rem_q == '0) begin
            desc_q <= next_q;
            st_q   <= ST_DREQ;
          end else if (mem_req_o && mem_gnt_i) begin
            beats_q <= cur_len;
            st_q    <= ST_BRCV;
          end
        end
        ST_BRCV: if (mem_rvalid_i) begin
          src_q   <= src_q + 32'd4;
          rem_q   <= rem_q - 1'b1;
          beats_q <= beats_q - 1'b1;
          if (beats_q == BLEN_W'(1)) st_q <= ST_BREQ;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_len_o)); // R10
  AST_LEN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_len_o != '0 && mem_len_o <= BLEN_W'(MAX_BURST)); // R4
  AST_SPACE_AT_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_gnt_i && st_q == ST_BREQ |-> free_i >= CNT_W'(mem_len_o)); // R5
endmodule

// File: rtl/fb_desc_fetch.sv
module fb_desc_fetch
  import fbf_pkg::*;
#(
  parameter  int FIFO_DEPTH = 32,
  parameter  int LEN_W      = 24,
  localparam int CNT_W      = $clog2(FIFO_DEPTH) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [31:0]       desc_addr_i,
  input  logic [1:0]        burst_sel_i,
  input  logic              hold_en_i,
  output logic              mem_req_o,
  output logic [31:0]       mem_addr_o,
  output logic [BLEN_W-1:0] mem_len_o,
  input  logic              mem_gnt_i,
  input  logic              mem_rvalid_i,
  input  logic [31:0]       mem_rdata_i,
  input  logic              pix_rd_i,
  output logic              pix_valid_o,
  output logic [31:0]       pix_data_o,
  output logic              pix_pal_o,
  output logic [31:0]       frame_id_o,
  output logic              underrun_o
);
  logic             idle, push, push_pal, prot_q, under_q;
  logic [CNT_W-1:0] free;
  logic [32:0]      head;
  logic [31:0]      last_q;

  fbf_fetch_ctl #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_ctl (
    .clk_i, .rst_ni, .start_i, .desc_addr_i, .burst_sel_i,
    .free_i(free), .idle_o(idle),
    .mem_req_o, .mem_addr_o, .mem_len_o, .mem_gnt_i, .mem_rvalid_i, .mem_rdata_i,
    .push_o(push), .push_pal_o(push_pal), .frame_id_o
  );

  fbf_fifo #(.WIDTH(33), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i(push), .wdata_i({push_pal, mem_rdata_i}),
    .pop_i(pix_rd_i), .rdata_o(head), .valid_o(pix_valid_o), .free_o(free)
  );

  assign pix_pal_o  = pix_valid_o && head[32];
  assign pix_data_o = pix_valid_o ? head[31:0] : (prot_q ? last_q : 32'd0);
  assign underrun_o = under_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prot_q  <= 1'b0;
      under_q <= 1'b0;
      last_q  <= '0;
    end else begin
      if (start_i && idle)           prot_q  <= hold_en_i;
      if (pix_rd_i && !pix_valid_o)  under_q <= 1'b1;
      if (pix_rd_i && pix_valid_o)   last_q  <= head[31:0];
    end
  end

  AST_UNDERRUN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |=> underrun_o); // R8
  AST_HOLD_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_q && !pix_valid_o && $past(pix_rd_i && pix_valid_o) |-> pix_data_o == $past(pix_data_o)); // R9
endmodule

// File: tb/fb_desc_fetch_bench.sv
`timescale 1ns/1ps
module fb_desc_fetch_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, hold_en;
  logic [31:0] desc_addr;
  logic [1:0]  bsel;
  logic        mem_req, mem_gnt, mem_rvalid;
  logic [31:0] mem_addr, mem_rdata;
  logic [4:0]  mem_len;
  logic        pix_rd, pix_valid, pix_pal, underrun;
  logic [31:0] pix_data, frame_id;

  always #4 clk = ~clk;

  fb_desc_fetch u_fb_desc_fetch (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .desc_addr_i(desc_addr),
    .burst_sel_i(bsel), .hold_en_i(hold_en),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_len_o(mem_len),
    .mem_gnt_i(mem_gnt), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .pix_rd_i(pix_rd), .pix_valid_o(pix_valid), .pix_data_o(pix_data),
    .pix_pal_o(pix_pal), .frame_id_o(frame_id), .underrun_o(underrun)
  );

  logic [31:0] dtab [64];
  int checks = 0, fails = 0;
  bit done = 0;

  // model state: display stream (m_), fetch side (f_), memory responder (b_)
  logic [31:0] m_ptr, m_src, f_desc, f_src, f_next, b_addr, last_w, fid_exp;
  int          m_rem, f_rem, b_beats, b_idx, occ;
  bit          m_pal, b_desc, exp_under, fid_pend;

  function automatic logic [31:0] memw(input logic [31:0] a);
    if (a[31:28] == 4'hD) return dtab[a[7:2]];
    return (a * 32'h9E37_79B1) ^ 32'h00C3_5A00;
  endfunction

  function automatic int blen_of(input logic [1:0] s);
    return (s == 2'd1) ? 8 : (s == 2'd2) ? 16 : 4;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic next_word(output logic [31:0] w, output bit pal);
    for (int g = 0; g < 8 && m_rem == 0; g++) begin
      m_src = dtab[m_ptr[7:2] + 6'd1];
      m_rem = int'(dtab[m_ptr[7:2] + 6'd3][23:0]);
      m_pal = dtab[m_ptr[7:2] + 6'd3][28];
      m_ptr = dtab[m_ptr[7:2]];
    end
    w = memw(m_src);
    pal = m_pal;
    m_src += 32'd4;
    m_rem--;
  endtask

  task automatic set_desc(input int slot, input logic [31:0] nxt, input logic [31:0] src,
                          input logic [31:0] fid, input logic [31:0] cmd);
    dtab[slot*4]   = nxt;
    dtab[slot*4+1] = src;
    dtab[slot*4+2] = fid;
    dtab[slot*4+3] = cmd;
  endtask

  task automatic run_phase(input logic [31:0] st_addr, input logic [1:0] s, input bit hold,
                           input int ncyc, input int pg, input int pv, input int pr);
    int blen;
    blen = blen_of(s);
    rst_n = 1'b0; start = 0; pix_rd = 0; mem_gnt = 0; mem_rvalid = 0; mem_rdata = '0;
    desc_addr = '0; bsel = '0; hold_en = 0;
    repeat (3) @(negedge clk);
    chk(mem_req == 0,   "R1", 32'(mem_req), 0);
    chk(pix_valid == 0, "R1", 32'(pix_valid), 0);
    chk(underrun == 0,  "R1", 32'(underrun), 0);
    chk(frame_id == 0,  "R1", frame_id, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_req == 0, "R1", 32'(mem_req), 0);
    m_ptr = st_addr; m_rem = 0; f_desc = st_addr; f_rem = 0;
    b_beats = 0; occ = 0; last_w = '0; exp_under = 0; fid_pend = 0;
    start = 1; desc_addr = st_addr; bsel = s; hold_en = hold;
    for (int cyc = 0; cyc < ncyc; cyc++) begin
      bit rd, pushing;
      logic [31:0] w;
      bit wp;
      @(negedge clk);
      chk(underrun == exp_under, "R8", 32'(underrun), 32'(exp_under));
      if (fid_pend) chk(frame_id == fid_exp, "R2", frame_id, fid_exp);
      fid_pend = 0;
      // R12: late start with different settings must be ignored
      start = (cyc == ncyc / 2);
      if (cyc == ncyc / 2) begin
        desc_addr = 32'hD000_0020; bsel = ~s; hold_en = ~hold;
      end
      mem_gnt = 0; mem_rvalid = 0; pushing = 0;
      if (b_beats > 0) begin
        if (($urandom % 100) < pv) begin
          mem_rvalid = 1; mem_rdata = memw(b_addr);
          if (b_desc) begin
            if (b_idx == 2) fid_exp = mem_rdata;
            if (b_idx == 3) fid_pend = 1;
            b_idx++;
          end else pushing = 1;
          b_addr += 32'd4; b_beats--;
        end
      end else if (mem_req && ($urandom % 100) < pg) begin
        mem_gnt = 1; b_addr = mem_addr; b_beats = int'(mem_len); b_idx = 0;
        b_desc = (mem_addr[31:28] == 4'hD);
        if (b_desc) begin
          chk(mem_addr == f_desc, "R6", mem_addr, f_desc);
          chk(mem_len == 5'd4, "R2", 32'(mem_len), 4);
          f_next = dtab[mem_addr[7:2]];
          f_src  = dtab[mem_addr[7:2] + 6'd1];
          f_rem  = int'(dtab[mem_addr[7:2] + 6'd3][23:0]);
          if (f_rem == 0) f_desc = f_next;
        end else begin
          int e;
          e = (f_rem < blen) ? f_rem : blen;
          chk(mem_addr == f_src, "R3", mem_addr, f_src);
          chk(int'(mem_len) == e, "R4", 32'(mem_len), 32'(e));
          chk(occ + int'(mem_len) <= 32, "R5", 32'(occ + int'(mem_len)), 32);
          f_src += 32'(4 * int'(mem_len));
          f_rem -= int'(mem_len);
          if (f_rem <= 0) begin f_rem = 0; f_desc = f_next; end
        end
      end
      rd = (($urandom % 100) < pr);
      if (!pix_valid)
        chk(pix_data == (hold ? last_w : 32'd0), "R9", pix_data, hold ? last_w : 32'd0);
      if (rd) begin
        if (pix_valid) begin
          next_word(w, wp);
          chk(pix_data == w, pushing ? "R11" : "R3", pix_data, w);
          chk(pix_pal == wp, "R7", 32'(pix_pal), 32'(wp));
          last_w = w; occ--;
        end else exp_under = 1;
      end
      if (pushing) occ++;
      pix_rd = rd;
    end
    @(negedge clk);
    start = 0; pix_rd = 0; mem_gnt = 0; mem_rvalid = 0;
    chk(frame_id != 32'h0000_0BAD, "R12", frame_id, 32'h0000_0BAD);
  endtask

  initial begin
    void'($urandom(32'h00C0_FFEE));
    for (int i = 0; i < 64; i++) dtab[i] = '0;
    set_desc(2, 32'hD000_0020, 32'h3000_0000, 32'h0000_0BAD, 32'd3);
    // true-colour self loop, 16-word bursts, slow display
    set_desc(0, 32'hD000_0000, 32'h1000_0000, 32'd11, 32'd37);
    run_phase(32'hD000_0000, 2'd2, 1'b1, 3000, 60, 70, 30);
    // palette/frame alternation, 4-word bursts, greedy display, no hold
    set_desc(0, 32'hD000_0010, 32'h2000_0000, 32'd21, (32'd1 << 28) | 32'd8);
    set_desc(1, 32'hD000_0000, 32'h2100_0000, 32'd22, 32'd20);
    run_phase(32'hD000_0000, 2'd0, 1'b0, 3000, 80, 80, 90);
    // zero-length descriptor in the chain, 8-word bursts
    set_desc(0, 32'hD000_0010, 32'h0000_0005, 32'd31, 32'd0);
    set_desc(1, 32'hD000_0000, 32'h2200_0000, 32'd32, 32'd13);
    run_phase(32'hD000_0000, 2'd1, 1'b1, 3000, 50, 50, 70);
    // select 3 decodes as 4 words; palette self loop; near-permanent popping
    set_desc(0, 32'hD000_0000, 32'h2300_0000, 32'd41, (32'd1 << 28) | 32'd5);
    run_phase(32'hD000_0000, 2'd3, 1'b1, 3000, 90, 90, 95);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL R3 watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule